// File: doc/BRIEF.md
# Op-Queue Serial Flash Sequencer

This block is a single-lane serial flash master that software runs by hand. It has two kinds of queue. The command queue holds 14-bit operation words. The byte-wide data queue has a transmit side and a receive side. An operation word carries an operation code and a byte count. A sequencer takes one word at a time from the head of the command queue and carries it out. It can drive chip select active or inactive. It can shift a number of transmit bytes out on the data-out line. It can clock a number of bytes in and place them on the receive side. A word with a code it does not recognise is taken from the queue and skipped.

Software stages a word on the write-data input and then pulses a push strobe. Transmit bytes enter the queue the same way. Received bytes are read from a read-data output and consumed with a pop strobe. The serial clock idles low (SPI mode 0), and each bit goes out most-significant bit first. Each half period of the serial clock lasts `CLK_DIV` system clocks. The sequencer states are IDLE, DECODE, WAIT, LOW, HIGH and NEXT:

- IDLE goes to DECODE when it takes a word.
- DECODE goes back to IDLE after a chip-select word, an unknown word or a word with zero length. It goes to WAIT for a byte burst.
- WAIT goes to LOW once a transmit byte is present, or once there is room on the receive side.
- LOW goes to HIGH after each half period.
- HIGH goes back to LOW, or to NEXT after the eighth bit.
- NEXT goes to WAIT while bytes remain, and to IDLE after the last byte.

Top module: `spi_opq_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, both empty flags are 1 and both full flags are 0.
- R2: An operation word has its byte length in bits [8:0] and its operation code in bits [13:9]. A word enters the command queue only on a cycle where `cmd_push` is 1. A value held on `cmd_wdata` without a push has no effect.
- R3: Code 0x00 drives `spi_cs_n` to 1 and code 0x01 drives it to 0. Chip select changes in response to nothing else.
- R4: Code 0x08 with length N shifts the next N bytes of the transmit queue out on `spi_mosi`. Bits go out most-significant first. Each bit is stable while `spi_sck` is high.
- R5: Code 0x0C with length N takes N bytes from `spi_miso`, sampled on the rising edge of `spi_sck` and most-significant bit first. Each byte is pushed to the receive queue.
- R6: While `rx_empty` is 0, `rx_rdata` shows the oldest received byte. That byte stays there until a `rx_pop` pulse consumes it.
- R7: Each data queue holds `DATA_DEPTH` (16) bytes and the command queue holds `CMD_DEPTH` (4) words. A push while the matching full flag is 1 is dropped.
- R8: `cmd_empty` is 1 only when the command queue is empty and the last operation has finished on the wire. No serial clock edge follows its assertion.
- R9: While a burst has no transmit byte, or has no free receive slot, the serial clock stays low and the operation stays pending.
- R10: A word with any other code, or a burst word with length 0, is removed from the queue with no serial activity. Chip select and the queued data are left unchanged.
- R11: A single operation can carry up to 511 bytes, the largest value of its length field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wdata | input | 14 | Staged operation word (code [13:9], length [8:0]) |
| cmd_push | input | 1 | Strobe that enqueues `cmd_wdata` |
| cmd_full | output | 1 | Command queue full |
| cmd_empty | output | 1 | Command queue empty and sequencer finished |
| tx_wdata | input | 8 | Transmit byte |
| tx_push | input | 1 | Strobe that enqueues `tx_wdata` |
| tx_full | output | 1 | Transmit queue full |
| rx_rdata | output | 8 | Oldest received byte |
| rx_pop | input | 1 | Strobe that consumes `rx_rdata` |
| rx_empty | output | 1 | Receive queue empty |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest condition to reach from the ports is a full command queue, because the sequencer normally takes each word almost as soon as it arrives. The bench holds the sequencer in WAIT by issuing a transmit burst while the transmit queue is empty. It then fills the queue with chip-select-high words and offers one more chip-select-low word, which must be dropped. Releasing the stall with one byte must leave chip select high. A second stall that is hard to reach is a full receive side in the middle of a 20-byte burst. The bench reaches it by leaving the first 16 bytes unread.

// File: rtl/spi_opq_pkg.sv
package spi_opq_pkg;
    localparam int LEN_W  = 9;
    localparam int CODE_W = 5;
    localparam int WORD_W = LEN_W + CODE_W;

    localparam logic [CODE_W-1:0] CODE_CS_HIGH = 5'h00;
    localparam logic [CODE_W-1:0] CODE_CS_LOW  = 5'h01;
    localparam logic [CODE_W-1:0] CODE_SEND    = 5'h08;
    localparam logic [CODE_W-1:0] CODE_RECV    = 5'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WAIT,
        ST_LOW,
        ST_HIGH,
        ST_NEXT
    } seq_state_t;
endpackage

// File: rtl/spi_opq_fifo.sv
module spi_opq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          wr_en, rd_en;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign wr_en = push && !full;
    assign rd_en = pop && !empty;
    assign rdata = mem[rptr];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_en) wptr <= wrap_inc(wptr);
            if (rd_en) rptr <= wrap_inc(rptr);
            case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wdata;
    end

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/spi_opq_engine.sv
module spi_opq_engine
    import spi_opq_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              cmd_pop,
    input  logic              tx_valid,
    input  logic [7:0]        tx_byte,
    output logic              tx_pop,
    input  logic              rx_ready,
    output logic [7:0]        rx_byte,
    output logic              rx_push,
    output logic              idle,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    seq_state_t        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [LEN_W-1:0]  len_q;
    logic              recv_q, cs_q;
    logic [7:0]        tx_sh_q, rx_sh_q;
    logic [2:0]        bit_q;
    logic [DIV_W-1:0]  div_q;
    logic              div_done, is_burst, slot_ok;

    assign div_done = (div_q == DIV_W'(CLK_DIV - 1));
    assign is_burst = ((code_q == CODE_SEND) || (code_q == CODE_RECV)) && (len_q != '0);
    assign slot_ok  = recv_q ? rx_ready : tx_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_DECODE;
            ST_DECODE: state_d = is_burst ? ST_WAIT : ST_IDLE;
            ST_WAIT:   if (slot_ok) state_d = ST_LOW;
            ST_LOW:    if (div_done) state_d = ST_HIGH;
            ST_HIGH:   if (div_done) state_d = (bit_q == 3'd7) ? ST_NEXT : ST_LOW;
            ST_NEXT:   state_d = (len_q == LEN_W'(1)) ? ST_IDLE : ST_WAIT;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_pop  = (state_q == ST_IDLE) && cmd_valid;
        tx_pop   = (state_q == ST_WAIT) && !recv_q && tx_valid;
        rx_push  = (state_q == ST_NEXT) && recv_q;
        idle     = (state_q == ST_IDLE);
        spi_sck  = (state_q == ST_HIGH);
        spi_cs_n = cs_q;
        spi_mosi = tx_sh_q[7];
        rx_byte  = rx_sh_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            len_q   <= '0;
            recv_q  <= 1'b0;
            cs_q    <= 1'b1;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            bit_q   <= '0;
            div_q   <= '0;
        end else begin
            if ((state_q == ST_LOW) || (state_q == ST_HIGH))
                div_q <= div_done ? '0 : div_q + DIV_W'(1);
            else
                div_q <= '0;
            unique case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    code_q <= cmd_word[WORD_W-1:LEN_W];
                    len_q  <= cmd_word[LEN_W-1:0];
                end
                ST_DECODE: begin
                    if (code_q == CODE_CS_HIGH) cs_q <= 1'b1;
                    if (code_q == CODE_CS_LOW)  cs_q <= 1'b0;
                    recv_q <= (code_q == CODE_RECV);
                end
                ST_WAIT: if (slot_ok) begin
                    tx_sh_q <= recv_q ? 8'h00 : tx_byte;
                    bit_q   <= '0;
                end
                ST_LOW: if (div_done) rx_sh_q <= {rx_sh_q[6:0], spi_miso};
                ST_HIGH: if (div_done) begin
                    tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                    bit_q   <= bit_q + 3'd1;
                end
                ST_NEXT: len_q <= len_q - LEN_W'(1);
                default: ;
            endcase
        end
    end

    // R3
    cs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> ($past(state_q) == ST_DECODE) &&
            (($past(code_q) == CODE_CS_HIGH) || ($past(code_q) == CODE_CS_LOW)));
    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
    // R5
    rx_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ($past(state_q) == ST_HIGH) && $past(recv_q));
    // R9
    tx_byte_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !recv_q && !tx_valid) |=> !spi_sck && !$past(tx_pop));
    // R10
    unknown_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && !is_burst && code_q != CODE_CS_HIGH && code_q != CODE_CS_LOW)
            |=> (state_q == ST_IDLE) && $stable(spi_cs_n));
endmodule

// File: rtl/spi_opq_master.sv
module spi_opq_master
    import spi_opq_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int CMD_DEPTH  = 4,
    parameter int DATA_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              cmd_push,
    output logic              cmd_full,
    output logic              cmd_empty,
    input  logic [7:0]        tx_wdata,
    input  logic              tx_push,
    output logic              tx_full,
    output logic [7:0]        rx_rdata,
    input  logic              rx_pop,
    output logic              rx_empty,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic [WORD_W-1:0] head_word;
    logic              cq_empty, cq_pop, eng_idle;
    logic [7:0]        tx_head, rx_in;
    logic              tq_empty, tq_pop, rq_full, rq_push;

    spi_opq_fifo #(.W(WORD_W), .DEPTH(CMD_DEPTH)) i_cmd_q (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .wdata(cmd_wdata), .full(cmd_full),
        .pop(cq_pop), .rdata(head_word), .empty(cq_empty));

    spi_opq_fifo #(.W(8), .DEPTH(DATA_DEPTH)) i_tx_q (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata), .full(tx_full),
        .pop(tq_pop), .rdata(tx_head), .empty(tq_empty));

    spi_opq_fifo #(.W(8), .DEPTH(DATA_DEPTH)) i_rx_q (
        .clk(clk), .rst_n(rst_n), .push(rq_push), .wdata(rx_in), .full(rq_full),
        .pop(rx_pop), .rdata(rx_rdata), .empty(rx_empty));

    spi_opq_engine #(.CLK_DIV(CLK_DIV)) i_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(!cq_empty), .cmd_word(head_word), .cmd_pop(cq_pop),
        .tx_valid(!tq_empty), .tx_byte(tx_head), .tx_pop(tq_pop),
        .rx_ready(!rq_full), .rx_byte(rx_in), .rx_push(rq_push),
        .idle(eng_idle),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    assign cmd_empty = cq_empty && eng_idle;

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_empty |-> !spi_sck);
endmodule

// File: tb/test_spi_opq_master.sv
`timescale 1ns/1ps
module test_spi_opq_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] cmd_wdata = '0;
    logic        cmd_push = 1'b0;
    logic        cmd_full, cmd_empty;
    logic [7:0]  tx_wdata = '0;
    logic        tx_push = 1'b0;
    logic        tx_full;
    logic [7:0]  rx_rdata;
    logic        rx_pop = 1'b0;
    logic        rx_empty;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    spi_opq_master i_spi_opq_master (
        .clk(clk), .rst_n(rst_n), .cmd_wdata(cmd_wdata), .cmd_push(cmd_push),
        .cmd_full(cmd_full), .cmd_empty(cmd_empty), .tx_wdata(tx_wdata),
        .tx_push(tx_push), .tx_full(tx_full), .rx_rdata(rx_rdata), .rx_pop(rx_pop),
        .rx_empty(rx_empty), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    // slave model: pattern byte k, updated on falling edges
    function automatic logic [7:0] pat(input int k);
        return 8'(k * 29 + 8'h5A);
    endfunction
    int fall_cnt = 0;
    int slv_base = 0;
    always @(negedge spi_sck) fall_cnt <= fall_cnt + 1;
    always_comb begin
        int idx;
        idx = fall_cnt - slv_base;
        spi_miso = pat(idx / 8)[7 - (idx % 8)];
    end

    // capture of data-out on rising edges
    int         cap_n = 0;
    logic [7:0] cap_sh = '0;
    logic [7:0] cap_mem [64];
    always @(posedge spi_sck) begin
        cap_sh <= {cap_sh[6:0], spi_mosi};
        if (cap_n % 8 == 7) cap_mem[(cap_n / 8) % 64] <= {cap_sh[6:0], spi_mosi};
        cap_n <= cap_n + 1;
    end

    localparam logic [7:0] TX_VEC [0:5] = '{8'hA5, 8'h3C, 8'h01, 8'h80, 8'hFF, 8'h00};

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [4:0] code, input logic [8:0] len);
        @(negedge clk);
        cmd_wdata = {code, len};
        cmd_push  = 1'b1;
        @(negedge clk);
        cmd_push  = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_wdata = b;
        tx_push  = 1'b1;
        @(negedge clk);
        tx_push  = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        while (rx_empty) @(negedge clk);
        b = rx_rdata;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_done();
        while (!cmd_empty) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b, b2;
        int base, bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        check(cmd_empty && rx_empty, "R1 empty flags", {cmd_empty, rx_empty}, 3);
        check(!cmd_full && !tx_full, "R1 full flags", {cmd_full, tx_full}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 staged word without strobe does nothing
        cmd_wdata = {5'h01, 9'd1};
        repeat (20) @(negedge clk);
        check(spi_cs_n == 1'b1 && cmd_empty, "R2 no push", spi_cs_n, 1);
        push_cmd(5'h01, 9'd1);
        wait_done();
        check(spi_cs_n == 1'b0, "R3 cs low", spi_cs_n, 0);

        // R4 / R8 table of single-byte sends
        for (int v = 0; v < 6; v++) begin
            base = cap_n;
            push_tx(TX_VEC[v]);
            push_cmd(5'h08, 9'd1);
            check(!cmd_empty, "R8 busy", cmd_empty, 0);
            wait_done();
            check(cap_n - base == 8, "R8 bits done at empty", cap_n - base, 8);
            @(negedge clk);
            check(cap_mem[(base / 8) % 64] == TX_VEC[v], "R4 byte", cap_mem[(base / 8) % 64], TX_VEC[v]);
        end

        // R7 transmit queue full, extra byte dropped
        for (int i = 0; i < 16; i++) push_tx(8'(i * 17 + 3));
        check(tx_full == 1'b1, "R7 tx_full", tx_full, 1);
        push_tx(8'hEE);
        base = cap_n;
        push_cmd(5'h08, 9'd16);
        wait_done();
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 16; i++)
            if (cap_mem[(base / 8 + i) % 64] != 8'(i * 17 + 3)) bad++;
        check(bad == 0, "R4 16-byte burst", bad, 0);
        base = cap_n;
        push_tx(8'h6D);
        push_cmd(5'h08, 9'd1);
        wait_done();
        @(negedge clk);
        check(cap_mem[(base / 8) % 64] == 8'h6D, "R7 dropped tx byte", cap_mem[(base / 8) % 64], 8'h6D);

        // R10 unknown code and zero-length burst are skipped
        base = cap_n;
        push_tx(8'h42);
        push_cmd(5'h05, 9'd3);
        push_cmd(5'h08, 9'd0);
        wait_done();
        repeat (4) @(negedge clk);
        check(cap_n == base, "R10 no clocks", cap_n - base, 0);
        check(spi_cs_n == 1'b0, "R10 cs kept", spi_cs_n, 0);
        push_cmd(5'h08, 9'd1);
        wait_done();
        @(negedge clk);
        check(cap_mem[(base / 8) % 64] == 8'h42, "R10 tx byte kept", cap_mem[(base / 8) % 64], 8'h42);

        // R9 stall on empty transmit queue, R7 command queue full
        base = cap_n;
        push_cmd(5'h08, 9'd1);
        repeat (40) @(negedge clk);
        check(!spi_sck && !cmd_empty && cap_n == base, "R9 tx stall", cap_n - base, 0);
        for (int i = 0; i < 4; i++) push_cmd(5'h00, 9'd1);
        check(cmd_full == 1'b1, "R7 cmd_full", cmd_full, 1);
        push_cmd(5'h01, 9'd1);
        push_tx(8'h99);
        wait_done();
        check(spi_cs_n == 1'b1, "R7 dropped cmd", spi_cs_n, 1);
        check(cap_mem[(base / 8) % 64] == 8'h99, "R9 resumed byte", cap_mem[(base / 8) % 64], 8'h99);

        // R5 / R6 receive
        push_cmd(5'h01, 9'd1);
        wait_done();
        slv_base = fall_cnt;
        push_cmd(5'h0C, 9'd4);
        wait_done();
        b = rx_rdata;
        repeat (10) @(negedge clk);
        check(!rx_empty && rx_rdata == b && b == pat(0), "R6 head held", rx_rdata, pat(0));
        bad = 0;
        for (int i = 0; i < 4; i++) begin
            pop_rx(b2);
            if (b2 != pat(i)) bad++;
        end
        check(bad == 0, "R5 rx bytes", bad, 0);
        check(rx_empty == 1'b1, "R6 drained", rx_empty, 1);

        // R9 stall on full receive queue
        slv_base = fall_cnt;
        push_cmd(5'h0C, 9'd20);
        repeat (900) @(negedge clk);
        base = fall_cnt;
        repeat (40) @(negedge clk);
        check(!cmd_empty && fall_cnt == base && !spi_sck, "R9 rx stall", fall_cnt - base, 0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            pop_rx(b2);
            if (b2 != pat(i)) bad++;
        end
        check(bad == 0, "R9 rx after stall", bad, 0);
        wait_done();

        // R11 longest single operation
        slv_base = fall_cnt;
        push_cmd(5'h0C, 9'd511);
        bad = 0;
        for (int i = 0; i < 511; i++) begin
            pop_rx(b2);
            if (b2 != pat(i)) bad++;
        end
        check(bad == 0, "R11 511 bytes", bad, 0);
        wait_done();
        repeat (10) @(negedge clk);
        check(rx_empty && cmd_empty, "R11 exact count", {rx_empty, cmd_empty}, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule